// File: doc/BRIEF.md
# Lowest Set Bit Locator

This block takes a word of `WIDTH` bits and reports where its lowest-index set bit sits. It does not walk the word bit by bit. A running-OR scan is built as a doubling network: each level combines every bit with the bit `1, 2, 4, ...` places below it, so the scan is complete after `log2(WIDTH)` levels. A comparison stage then looks at every bit position at once. The marked position is the only one where the running OR is 1 and the running OR one place below it is still 0.

The result is given in three forms: a one-hot marker word, the binary position of that marker, and a flag that is high when any input bit is set. A parameter selects whether the result passes through an output register (one cycle of latency) or goes straight to the ports. By default the output register is used. It clears on an active-low asynchronous reset.

Top module: `first_one_detect`

## Requirements
- R1: With a nonzero input, `firstHot` has its single set bit at the lowest-index set bit of `inWord`. Bit 0 of `inWord` is the lowest index, and it is treated as having no set bit below it.
- R2: `firstHot` never has more than one bit set.
- R3: `found` is 1 exactly when the input word it reports on has at least one bit set.
- R4: An all-zero input produces `firstHot` = 0, `firstIdx` = 0 and `found` = 0.
- R5: `firstIdx` is the unsigned binary position of the marked bit. Examples: bit 0 gives 0, bit 31 gives 31.
- R6: With `REG_OUT` = 1 (the default), the outputs seen after a rising clock edge reflect the `inWord` value sampled at that edge, which is one cycle of latency.
- R7: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| inWord | input | WIDTH (32) | Word to be searched |
| firstHot | output | WIDTH (32) | One-hot marker at the lowest set bit, or zero |
| firstIdx | output | $clog2(WIDTH) (5) | Binary position of the marker, or zero |
| found | output | 1 | High when the searched word had any bit set |

## Verification
The clocked properties assume that `inWord` is stable around each rising edge and holds a known value from the first edge after reset. They also assume the registered variant, since each output is compared with the input sampled one edge earlier. The stimulus meets these assumptions by driving `inWord` only on falling edges, starting from time zero. The same stimulus covers the all-zero word, the all-ones word, every single-bit word, pairs of set bits, random words and sparse random words whose lowest set bit lies high in the word.

// File: rtl/fod_pkg.sv
package fod_pkg;

  typedef struct packed {
    logic loadOut;
    logic bypassOut;
  } fodStrobe_t;

endpackage

// File: rtl/fod_prefix_scan.sv
module fod_prefix_scan #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] bitsIn,
  output logic [WIDTH-1:0] runOr
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [LEVELS:0][WIDTH-1:0] stage;

  assign stage[0] = bitsIn;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
    localparam int DIST = 1 << lvl;
    for (genvar pos = 0; pos < WIDTH; pos++) begin : g_pos
      if (pos >= DIST) begin : g_merge
        assign stage[lvl+1][pos] = stage[lvl][pos] | stage[lvl][pos-DIST];
      end else begin : g_pass
        assign stage[lvl+1][pos] = stage[lvl][pos];
      end
    end
  end

  assign runOr = stage[LEVELS];
endmodule

// File: rtl/fod_edge_mark.sv
module fod_edge_mark #(
  parameter int WIDTH = 32,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] runOr,
  output logic [WIDTH-1:0] hotMark,
  output logic [IDXW-1:0]  hotIdx,
  output logic             anySet
);
  logic [WIDTH-1:0] runBelow;

  assign runBelow = {runOr[WIDTH-2:0], 1'b0};
  assign hotMark  = runOr & ~runBelow;
  assign anySet   = runOr[WIDTH-1];

  always_comb begin
    hotIdx = '0;
    for (int pos = 0; pos < WIDTH; pos++) begin
      if (hotMark[pos]) hotIdx = hotIdx | IDXW'(pos);
    end
  end
endmodule

// File: rtl/fod_ctrl.sv
module fod_ctrl
  import fod_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  output fodStrobe_t strobe
);
  assign strobe.loadOut   = REG_OUT;
  assign strobe.bypassOut = !REG_OUT;
endmodule

// File: rtl/fod_datapath.sv
module fod_datapath
  import fod_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fodStrobe_t       strobe,
  input  logic [WIDTH-1:0] inWord,
  output logic [WIDTH-1:0] firstHot,
  output logic [IDXW-1:0]  firstIdx,
  output logic             found
);
  logic [WIDTH-1:0] runOr;
  logic [WIDTH-1:0] hotMark;
  logic [IDXW-1:0]  hotIdx;
  logic             anySet;

  logic [WIDTH-1:0] hotQ;
  logic [IDXW-1:0]  idxQ;
  logic             foundQ;

  fod_prefix_scan #(.WIDTH(WIDTH)) i_scan (
    .bitsIn (inWord),
    .runOr  (runOr)
  );

  fod_edge_mark #(.WIDTH(WIDTH)) i_mark (
    .runOr   (runOr),
    .hotMark (hotMark),
    .hotIdx  (hotIdx),
    .anySet  (anySet)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hotQ   <= '0;
      idxQ   <= '0;
      foundQ <= 1'b0;
    end else if (strobe.loadOut) begin
      hotQ   <= hotMark;
      idxQ   <= hotIdx;
      foundQ <= anySet;
    end
  end

  assign firstHot = strobe.bypassOut ? hotMark : hotQ;
  assign firstIdx = strobe.bypassOut ? hotIdx  : idxQ;
  assign found    = strobe.bypassOut ? anySet  : foundQ;
endmodule

// File: rtl/first_one_detect.sv
module first_one_detect
  import fod_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] inWord,
  output logic [WIDTH-1:0] firstHot,
  output logic [IDXW-1:0]  firstIdx,
  output logic             found
);
  fodStrobe_t strobe;

  fod_ctrl #(.REG_OUT(REG_OUT)) i_ctrl (
    .strobe (strobe)
  );

  fod_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inWord   (inWord),
    .firstHot (firstHot),
    .firstIdx (firstIdx),
    .found    (found)
  );
endmodule

// File: rtl/first_one_detect_chk.sv
module first_one_detect_chk #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] inWord,
  input logic [WIDTH-1:0] firstHot,
  input logic [IDXW-1:0]  firstIdx,
  input logic             found
);
  // R2: never more than one marker bit
  a_r2_single_marker: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(firstHot));

  // R3: flag agrees with presence of a marker
  a_r3_flag_vs_marker: assert property (@(posedge clk) disable iff (!rstN)
    found == (firstHot != '0));

  // R4: nothing found means index zero
  a_r4_idx_zero: assert property (@(posedge clk) disable iff (!rstN)
    !found |-> firstIdx == '0);

  // R5: index points at the marker
  a_r5_idx_points: assert property (@(posedge clk) disable iff (!rstN)
    found |-> firstHot[firstIdx]);

  // R7: outputs cleared under reset
  always @(negedge clk) begin
    if (!rstN) begin
      a_r7_reset_clear: assert (firstHot == '0 && firstIdx == '0 && !found);
    end
  end

  if (REG_OUT) begin : g_reg
    // R1 / R6: marker is a set input bit with no set input bit below it
    a_r1_lowest_bit: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> ((firstHot & $past(inWord)) == firstHot) &&
               (((firstHot - 1'b1) & $past(inWord)) == '0));

    // R6 / R3: flag follows the word sampled one edge before
    a_r6_flag_latency: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> found == ($past(inWord) != '0));
  end
endmodule

bind first_one_detect first_one_detect_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inWord   (inWord),
  .firstHot (firstHot),
  .firstIdx (firstIdx),
  .found    (found)
);

// File: tb/test_first_one_detect.sv
module test_first_one_detect;
  localparam int WIDTH = 32;
  localparam int IDXW  = 5;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [WIDTH-1:0] inWord = '0;
  logic [WIDTH-1:0] firstHot;
  logic [IDXW-1:0]  firstIdx;
  logic             found;

  int vecCount = 0;
  int missCount = 0;
  logic [WIDTH-1:0] pendQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  first_one_detect #(.WIDTH(WIDTH), .REG_OUT(1'b1)) i_first_one_detect (
    .clk      (clk),
    .rstN     (rstN),
    .inWord   (inWord),
    .firstHot (firstHot),
    .firstIdx (firstIdx),
    .found    (found)
  );

  // Behavioural reference: plain search from bit 0 upward
  task automatic checkAgainst(input logic [WIDTH-1:0] word);
    logic [WIDTH-1:0] expHot = '0;
    int expIdx = 0;
    logic expFound = 1'b0;
    for (int pos = 0; pos < WIDTH; pos++) begin
      if (word[pos] && !expFound) begin
        expFound = 1'b1;
        expHot[pos] = 1'b1;
        expIdx = pos;
      end
    end
    vecCount++;
    if (firstHot !== expHot) begin
      missCount++;
      $display("FAIL R1 word=%h firstHot=%h expected=%h", word, firstHot, expHot);
    end else if ($countones(firstHot) > 1) begin
      missCount++;
      $display("FAIL R2 word=%h firstHot=%h expected at most one bit", word, firstHot);
    end else if (found !== expFound) begin
      missCount++;
      $display("FAIL R3 word=%h found=%b expected=%b", word, found, expFound);
    end else if (firstIdx !== IDXW'(expIdx)) begin
      missCount++;
      if (!expFound)
        $display("FAIL R4 word=%h firstIdx=%0d expected=0", word, firstIdx);
      else
        $display("FAIL R5 word=%h firstIdx=%0d expected=%0d", word, firstIdx, expIdx);
    end
  endtask

  // R6: apply on a falling edge; the result after the next rising edge is
  // compared at the falling edge that follows
  task automatic applyWord(input logic [WIDTH-1:0] word);
    @(negedge clk);
    if (pendQ.size() > 0) checkAgainst(pendQ.pop_front());
    inWord = word;
    pendQ.push_back(word);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    missCount++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    inWord = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R7: outputs cleared while reset is held, with a nonzero input
    vecCount++;
    if (firstHot !== '0 || firstIdx !== '0 || found !== 1'b0) begin
      missCount++;
      $display("FAIL R7 hot=%h idx=%0d found=%b expected all zero", firstHot, firstIdx, found);
    end
    rstN = 1'b1;
    inWord = '0;
    pendQ.push_back('0);

    applyWord('0);                 // R4 all zero
    applyWord(32'hFFFF_FFFF);      // R1 all ones -> bit 0
    applyWord('0);
    for (int pos = 0; pos < WIDTH; pos++) applyWord(32'h1 << pos);  // R5 each position
    for (int pos = 1; pos < WIDTH; pos++) applyWord((32'h1 << pos) | 32'h8000_0000);
    applyWord(32'h8000_0000);      // R5 top bit -> 31
    for (int k = 0; k < 300; k++) applyWord($urandom());
    for (int k = 0; k < 200; k++) begin
      logic [WIDTH-1:0] w;
      int sh;
      sh = $urandom_range(WIDTH-1, 0);
      w = ($urandom() & $urandom()) << sh;
      applyWord(w);
    end
    applyWord('0);
    applyWord('0);                 // flush; last zero checked below
    @(negedge clk);
    checkAgainst(pendQ.pop_front());

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule